// File: doc/BRIEF.md
# Threshold on/off link flow control

This block joins a flit sender to a flit receiver over a channel whose forward
path (flits) and return path (flow-control level) each have a configurable
latency. The receiver keeps its flits in a FIFO and tracks how many entries are
still free. Instead of returning a credit for every flit, it drives one level,
"off" or "on". The level changes only when the free count crosses one of two
thresholds. The sender injects flits only while the level it sees is "on".

The low threshold sets "off" when the free count drops below it. The high
threshold sets "on" again when the free count climbs above it. Between the two
thresholds the last state is kept, so the level cannot chatter. The low
threshold must cover every flit that can still arrive once "off" has been
decided, so the FIFO never overflows. The high threshold keeps enough flits
queued to hide the round trip that follows the return of "on".

Elaboration-time checks reject these settings:
- a low threshold smaller than the forward delay plus the return delay plus two;
- a high threshold not above the low threshold;
- a high threshold not below the depth.

After reset the FIFO is empty and the link is in the "on" state.

Top module: `onoff_link`

## Requirements
- R1: After reset, sink_valid is 0, rx_off is 0 and src_ready is 1.
- R2: rx_off is 1 in the cycle after any cycle in which the free count (DEPTH minus occupancy) is below FOFF.
- R3: With sink_pop held at 0 and src_valid held at 1, the sender accepts exactly min(DEPTH, DEPTH-FOFF+FWD_DLY+RET_DLY+2) flits, and no write ever targets a full FIFO.
- R4: rx_off is 0 in the cycle after any cycle in which the free count is above FON.
- R5: While the free count stays from FOFF to FON inclusive, rx_off keeps its previous value.
- R6: src_ready equals the inverse of rx_off delayed by exactly RET_DLY clock cycles.
- R7: A flit accepted (src_valid and src_ready high at a rising edge) into an empty FIFO makes sink_valid 1 after exactly FWD_DLY further rising edges, with sink_data equal to the accepted src_data.
- R8: Every accepted flit is delivered to sink_data exactly once, in acceptance order, for any mix of injection and pop patterns.
- R9: sink_pop while sink_valid is 0 has no effect on the FIFO occupancy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Sender has a flit to inject |
| src_data | input | FLIT_W | Flit presented by the sender |
| src_ready | output | 1 | Sender-side on level; the flit is taken when both are high |
| sink_valid | output | 1 | FIFO holds at least one flit |
| sink_data | output | FLIT_W | Oldest flit in the FIFO |
| sink_pop | input | 1 | Consumer removes the oldest flit |
| rx_off | output | 1 | Receiver-side off state (1 = off) |

## Verification
Two situations are hard to reach from the ports. The first is the last few
flits still in flight arriving after the receiver has already turned off. The
bench gets there by injecting without a break into a FIFO that is never popped,
counting accepted flits against the computed limit and timing the off edge at
both ends of the link.

The second is the hysteresis band, where the state must hold. The bench drains
the FIFO to a free count strictly between the thresholds and stops there for
many cycles. It then removes a few more flits and times the return of "on"
against the return delay. A table of mixed injection and pop rates then stresses
ordering through repeated threshold crossings.

// File: rtl/onoff_pkg.sv
package onoff_pkg;
   // Smallest low threshold that absorbs every flit in flight after "off" is decided
   function automatic int min_low_thr(input int fwd_dly, input int ret_dly);
      return fwd_dly + ret_dly + 2;
   endfunction
endpackage

// File: rtl/onoff_delay.sv
module onoff_delay #(
   parameter int          W      = 1,
   parameter int          STAGES = 1,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   generate
      if (STAGES == 0) begin : g_wire
         assign d_out = d_in;
      end else begin : g_regs
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST;
            end else begin
               stg[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign d_out = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/onoff_fifo.sv
module onoff_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   input  logic          rd,
   output logic [W-1:0]  rdata,
   output logic          not_empty,
   output logic          full,
   output logic [CW-1:0] free
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP  = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] occ;
   logic          do_wr, do_rd;

   assign full      = (occ == CAP);
   assign not_empty = (occ != '0);
   assign do_wr     = wr && !full;
   assign do_rd     = rd && not_empty;
   assign rdata     = mem[rptr];
   assign free      = CAP - occ;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
         if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/onoff_rx_ctl.sv
module onoff_rx_ctl #(
   parameter int CW      = 5,
   parameter int LOW_THR = 6,
   parameter int HIGH_THR = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] free,
   output logic          off_q
);
   localparam logic [CW-1:0] LO = CW'(LOW_THR);
   localparam logic [CW-1:0] HI = CW'(HIGH_THR);

   always_ff @(posedge clk) begin
      if (!rst_n)          off_q <= 1'b0;
      else if (free < LO)  off_q <= 1'b1;
      else if (free > HI)  off_q <= 1'b0;
   end
endmodule

// File: rtl/onoff_tx_gate.sv
module onoff_tx_gate #(
   parameter int W = 8
) (
   input  logic         go,
   input  logic         src_valid,
   input  logic [W-1:0] src_data,
   output logic         src_ready,
   output logic [W:0]   launch
);
   assign src_ready = go;
   assign launch    = {src_valid && go, src_data};
endmodule

// File: rtl/onoff_link.sv
module onoff_link #(
   parameter int FLIT_W  = 8,
   parameter int DEPTH   = 16,
   parameter int FOFF    = 6,
   parameter int FON     = 10,
   parameter int FWD_DLY = 2,
   parameter int RET_DLY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [FLIT_W-1:0] src_data,
   output logic              src_ready,
   output logic              sink_valid,
   output logic [FLIT_W-1:0] sink_data,
   input  logic              sink_pop,
   output logic              rx_off
);
   import onoff_pkg::*;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("onoff_link: DEPTH must be at least 2");
   end
   if (FOFF < min_low_thr(FWD_DLY, RET_DLY)) begin : g_bad_low
      $error("onoff_link: FOFF too small for the link round trip");
   end
   if (FON <= FOFF) begin : g_bad_band
      $error("onoff_link: FON must exceed FOFF");
   end
   if (FON >= DEPTH) begin : g_bad_high
      $error("onoff_link: FON must be below DEPTH");
   end

   logic [FLIT_W:0]   launch, arrive;
   logic              fifo_wr, fifo_full, tx_go;
   logic [CW-1:0]     free_cnt;

   onoff_tx_gate #(.W(FLIT_W)) u_tx (
      .go(tx_go), .src_valid(src_valid), .src_data(src_data),
      .src_ready(src_ready), .launch(launch)
   );

   onoff_delay #(.W(FLIT_W + 1), .STAGES(FWD_DLY), .RST('0)) u_fwd (
      .clk(clk), .rst_n(rst_n), .d_in(launch), .d_out(arrive)
   );

   assign fifo_wr = arrive[FLIT_W];

   onoff_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr(fifo_wr), .wdata(arrive[FLIT_W-1:0]),
      .rd(sink_pop), .rdata(sink_data),
      .not_empty(sink_valid), .full(fifo_full), .free(free_cnt)
   );

   onoff_rx_ctl #(.CW(CW), .LOW_THR(FOFF), .HIGH_THR(FON)) u_rx (
      .clk(clk), .rst_n(rst_n), .free(free_cnt), .off_q(rx_off)
   );

   onoff_delay #(.W(1), .STAGES(RET_DLY), .RST(1'b1)) u_ret (
      .clk(clk), .rst_n(rst_n), .d_in(~rx_off), .d_out(tx_go)
   );
endmodule

// File: rtl/onoff_link_chk.sv
module onoff_link_chk #(
   parameter int DEPTH = 16,
   parameter int FOFF  = 6,
   parameter int FON   = 10,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          full,
   input logic [CW-1:0] free,
   input logic          rx_off
);
   localparam logic [CW-1:0] LO = CW'(FOFF);
   localparam logic [CW-1:0] HI = CW'(FON);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);

   assert_off_below_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (free < LO) |=> rx_off);

   assert_on_above_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (free > HI) |=> !rx_off);

   assert_hold_in_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (free >= LO && free <= HI && rst_n) |=> $stable(rx_off));
endmodule

bind onoff_link onoff_link_chk #(.DEPTH(DEPTH), .FOFF(FOFF), .FON(FON), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .full(fifo_full),
   .free(free_cnt), .rx_off(rx_off)
);

// File: tb/tb_onoff_link.sv
module tb_onoff_link;
   localparam int W = 8, DEPTH = 16, FOFF = 6, FON = 10, FWD = 2, RET = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic src_valid = 1'b0, sink_pop = 1'b0;
   logic [W-1:0] src_data = '0;
   logic src_ready, sink_valid, rx_off;
   logic [W-1:0] sink_data;

   always #5 clk = ~clk;

   onoff_link #(.FLIT_W(W), .DEPTH(DEPTH), .FOFF(FOFF), .FON(FON),
                .FWD_DLY(FWD), .RET_DLY(RET)) dut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_ready(src_ready), .sink_valid(sink_valid), .sink_data(sink_data),
      .sink_pop(sink_pop), .rx_off(rx_off)
   );

   int total = 0, bad = 0;
   logic [W-1:0] sb [4096];
   int sb_wr = 0, sb_rd = 0;
   logic [W-1:0] next_d = 8'h01;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // {cycles, inject period, pop period}
   localparam logic [15:0] PAT [6] = '{
      {8'd40, 4'd1, 4'd1}, {8'd60, 4'd1, 4'd3}, {8'd60, 4'd2, 4'd1},
      {8'd80, 4'd1, 4'd2}, {8'd50, 4'd3, 4'd3}, {8'd40, 4'd1, 4'd4}
   };

   // at a negedge: decide injection for the coming edge and record it
   task automatic drive_inject(input bit want);
      src_valid = want;
      src_data  = next_d;
      if (want && src_ready) begin
         sb[sb_wr] = next_d;
         sb_wr++;
         next_d = next_d + 8'd1;
      end
   endtask

   task automatic drive_pop(input bit want, input string tag);
      if (want && sink_valid) begin
         chk(sb_rd < sb_wr && sink_data == sb[sb_rd], tag, int'(sink_data), int'(sb[sb_rd]));
         sb_rd++;
         sink_pop = 1'b1;
      end else begin
         sink_pop = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int acc, n_off, n_rdy, p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sink_valid == 1'b0, "R1 sink_valid", int'(sink_valid), 0);
      chk(rx_off == 1'b0, "R1 rx_off", int'(rx_off), 0);
      chk(src_ready == 1'b1, "R1 src_ready", int'(src_ready), 1);

      // R7 single flit latency
      drive_inject(1'b1);
      @(negedge clk);
      src_valid = 1'b0;
      for (int k = 0; k < FWD; k++) begin
         chk(sink_valid == 1'b0, "R7 early valid", int'(sink_valid), 0);
         @(negedge clk);
      end
      chk(sink_valid == 1'b1, "R7 valid at latency", int'(sink_valid), 1);
      chk(sink_data == sb[0], "R7 data", int'(sink_data), int'(sb[0]));

      // R9 pop it, then keep popping while empty
      drive_pop(1'b1, "R9 first pop");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         sink_pop = 1'b1;
      end
      @(negedge clk);
      sink_pop = 1'b0;
      chk(sink_valid == 1'b0, "R9 empty after pops", int'(sink_valid), 0);

      // R2/R3/R6 fill with no pops; edges counted from the first acceptance
      acc = 0; n_off = -1; n_rdy = -1;
      for (int n = 0; n < 60; n++) begin
         if (src_ready) acc++;
         drive_inject(1'b1);
         @(negedge clk);
         if (rx_off && n_off < 0) n_off = n;
         if (!src_ready && n_rdy < 0) n_rdy = n;
      end
      src_valid = 1'b0;
      chk(acc == DEPTH - FOFF + FWD + RET + 2 || acc == DEPTH, "R3 accepted count", acc,
          (DEPTH - FOFF + FWD + RET + 2 < DEPTH) ? DEPTH - FOFF + FWD + RET + 2 : DEPTH);
      chk(acc == DEPTH, "R3 fill reaches depth", acc, DEPTH);
      chk(n_off == DEPTH - FOFF + 1 + FWD, "R2 off edge", n_off, DEPTH - FOFF + 1 + FWD);
      chk(n_rdy == n_off + RET, "R6 ready drop delay", n_rdy, n_off + RET);

      // R5 drain into the band (free 8) and hold
      for (int k = 0; k < 8; k++) begin
         drive_pop(1'b1, "R8 drain order");
         @(negedge clk);
      end
      sink_pop = 1'b0;
      repeat (20) @(negedge clk);
      chk(rx_off == 1'b1, "R5 hold off in band", int'(rx_off), 1);
      chk(src_ready == 1'b0, "R5 ready stays low", int'(src_ready), 0);

      // R4/R6 three more pops push free to 11
      for (int k = 0; k < 3; k++) begin
         drive_pop(1'b1, "R8 drain order");
         @(negedge clk);
      end
      sink_pop = 1'b0;
      p = 0;
      chk(rx_off == 1'b1, "R4 off before update", int'(rx_off), 1);
      @(negedge clk); p++;
      chk(rx_off == 1'b0, "R4 on after crossing", int'(rx_off), 0);
      while (p < RET) begin
         chk(src_ready == 1'b0, "R6 ready still low", int'(src_ready), 0);
         @(negedge clk); p++;
      end
      chk(src_ready == 1'b0, "R6 ready low at edge", int'(src_ready), 0);
      @(negedge clk);
      chk(src_ready == 1'b1, "R6 ready back high", int'(src_ready), 1);

      // R8 table walk of mixed rates
      for (int e = 0; e < 6; e++) begin
         for (int c = 0; c < int'(PAT[e][15:8]); c++) begin
            drive_inject((c % int'(PAT[e][7:4])) == 0);
            drive_pop((c % int'(PAT[e][3:0])) == 0, "R8 order");
            @(negedge clk);
         end
      end
      src_valid = 1'b0;
      for (int c = 0; c < 200 && (sb_rd < sb_wr || sink_valid); c++) begin
         drive_pop(1'b1, "R8 final drain");
         @(negedge clk);
      end
      sink_pop = 1'b0;
      @(negedge clk);
      chk(sb_rd == sb_wr, "R8 all delivered", sb_rd, sb_wr);
      chk(sink_valid == 1'b0, "R8 empty at end", int'(sink_valid), 0);
      chk(rx_off == 1'b0, "R4 on when empty", int'(rx_off), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule